// File: doc/BRIEF.md
# Time Base and Watchdog Interrupt Controller

This block turns a system clock enable into a periodic time base and a watchdog, and presents either of them on a single interrupt pin. A 16-bit prescaler advances on every enabled clock while the system is running and the time base has been switched on. A 3-bit selector picks one of eight prescaler bits as the time base tap. Each time the selected tap rolls over, the time base source produces a one-cycle low pulse. A small watchdog counts those periods. It raises a sticky timeout flag when four periods pass without a clear.

The host drives the block with decoded one-cycle command strobes. The commands cover: system on and off, start the time base, start the watchdog, clear the timer, clear the watchdog, and enable or disable the interrupt pin. The pin is delivered as a data and output-enable pair. When the enable is low, the pad is meant to float. A flag input marks an external clock source. While it is set, the system-off command has no effect.

Top module: `tbwd_irq_ctrl`

## Requirements
- R1: After reset, `irq_oe` is 0 and `irq_o` is 1, the system is off, and the time base is stopped. No low level appears on `irq_o` until commands start it.
- R2: In time base mode, with the interrupt enabled and `clk_en` held at 1, `irq_o` is low for exactly one cycle every 2^(9+`tap_sel`) cycles. The selected tap is prescaler bit 8+`tap_sel`. The first low comes 2^(9+`tap_sel`) cycles after the clear edge.
- R3: The prescaler advances only in cycles where `clk_en` is 1. With `clk_en` alternating 1,0,1,0 starting on the clear cycle, the first low arrives twice as late as it does with `clk_en` held at 1.
- R4: `cmd_tmr_en` starts the time base and routes its pulse to the pin, and the watchdog flag is then not visible. `cmd_wdt_en` starts the time base and routes the watchdog flag instead. The pulse is then not visible.
- R5: In watchdog mode, `irq_o` goes low four time base periods after a watchdog clear, that is 2048 cycles at `tap_sel`=0. It then stays low until `cmd_clr_wdt` or `cmd_irq_dis`.
- R6: `cmd_clr_wdt` zeroes the prescaler, the watchdog period count and the timeout flag. `cmd_clr_tmr` zeroes only the prescaler, and the watchdog keeps the periods already counted.
- R7: `cmd_irq_dis` drops `irq_oe` to 0, holds `irq_o` at 1 and clears the watchdog timeout flag. `cmd_irq_en` raises `irq_oe` so that the selected source drives `irq_o`.
- R8: `cmd_sys_dis` freezes the prescaler and the watchdog with their counts held, and no pulse appears. `cmd_sys_en` resumes counting from the held value.
- R9: While `ext_clk` is 1, `cmd_sys_dis` is ignored and the time base keeps producing pulses.
- R10: Commands given in the same cycle resolve as follows. `cmd_irq_dis` wins over `cmd_irq_en`. `cmd_wdt_en` wins over `cmd_tmr_en`. `cmd_sys_en` wins over an ignored `cmd_sys_dis`. A clear command suppresses a rollover that would fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Time base tick enable |
| ext_clk | input | 1 | Set when the clock comes from an external source; blocks system-off |
| tap_sel | input | 3 | Prescaler tap choice, bit 8+tap_sel |
| cmd_sys_en | input | 1 | Strobe: system on |
| cmd_sys_dis | input | 1 | Strobe: system off (power-down) |
| cmd_tmr_en | input | 1 | Strobe: start time base, route it to the pin |
| cmd_wdt_en | input | 1 | Strobe: start time base, route watchdog flag to the pin |
| cmd_clr_tmr | input | 1 | Strobe: clear prescaler |
| cmd_clr_wdt | input | 1 | Strobe: clear watchdog and prescaler |
| cmd_irq_en | input | 1 | Strobe: enable the interrupt pin driver |
| cmd_irq_dis | input | 1 | Strobe: float the interrupt pin, release timeout |
| irq_o | output | 1 | Interrupt pin data, active low |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions assume that every command input is a strobe decoded upstream. They also assume that all inputs hold known values from reset onward. They assume no timing relation between `tap_sel` or `ext_clk` changes and the prescaler state. A second rollover within one cycle of the first is therefore impossible only because the taps are hundreds of ticks apart. The stimulus respects these assumptions. It drives each strobe for one cycle only and clears it at the next falling edge. It draws commands, tap changes and `clk_en` gaps from a seeded `$urandom` stream at low rates, so that watchdog timeouts still occur between clears.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;

  typedef enum logic {
    SRC_TIMEBASE = 1'b0,
    SRC_WATCHDOG = 1'b1
  } irq_src_e;

  typedef struct packed {
    logic     sys_run;
    logic     tb_on;
    irq_src_e src;
    logic     irq_en;
  } mode_t;

endpackage

// File: rtl/tbwd_mode_ctrl.sv
module tbwd_mode_ctrl
  import tbwd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ext_clk,
  input  logic  sys_on_cmd,
  input  logic  sys_off_cmd,
  input  logic  tmr_on_cmd,
  input  logic  wdt_on_cmd,
  input  logic  irq_on_cmd,
  input  logic  irq_off_cmd,
  output mode_t mode
);

  mode_t mode_q;
  mode_t mode_d;

  // Next-state: off beats on (unless external clock), watchdog beats timer,
  // interrupt disable beats enable.
  always_comb begin
    mode_d = mode_q;
    if (sys_off_cmd && !ext_clk) begin
      mode_d.sys_run = 1'b0;
    end else if (sys_on_cmd) begin
      mode_d.sys_run = 1'b1;
    end
    if (wdt_on_cmd) begin
      mode_d.tb_on = 1'b1;
      mode_d.src   = SRC_WATCHDOG;
    end else if (tmr_on_cmd) begin
      mode_d.tb_on = 1'b1;
      mode_d.src   = SRC_TIMEBASE;
    end
    if (irq_off_cmd) begin
      mode_d.irq_en = 1'b0;
    end else if (irq_on_cmd) begin
      mode_d.irq_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{sys_run: 1'b0, tb_on: 1'b0, src: SRC_TIMEBASE, irq_en: 1'b0};
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/tbwd_prescaler.sv
module tbwd_prescaler #(
  parameter int PRE_W    = 16,
  parameter int TAP_BASE = 8,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             clear,
  input  logic [SEL_W-1:0] tap_sel,
  output logic [PRE_W-1:0] count,
  output logic             roll_now,
  output logic             pulse
);

  localparam int NTAP = 1 << SEL_W;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic [NTAP-1:0]  tap_full;
  logic             pulse_q;

  // One detector per tap: all bits up to and including the tap are ones,
  // so the next advance rolls that tap over.
  generate
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
      assign tap_full[t] = &cnt_q[TAP_BASE+t:0];
    end
  endgenerate

  assign roll_now = advance && !clear && tap_full[tap_sel];

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (advance) begin
      cnt_d = cnt_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= roll_now;
    end
  end

  assign count = cnt_q;
  assign pulse = pulse_q;

endmodule

// File: rtl/tbwd_watchdog.sv
module tbwd_watchdog #(
  parameter int PERIODS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic period_evt,
  input  logic clr_cmd,
  input  logic release_cmd,
  output logic timeout
);

  localparam int CW = (PERIODS > 1) ? $clog2(PERIODS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIODS - 1);

  logic [CW-1:0] per_q;
  logic [CW-1:0] per_d;
  logic          flag_q;
  logic          flag_d;

  always_comb begin
    per_d  = per_q;
    flag_d = flag_q;
    if (clr_cmd) begin
      per_d  = '0;
      flag_d = 1'b0;
    end else if (armed && period_evt) begin
      if (per_q == LAST) begin
        per_d  = '0;
        flag_d = 1'b1;
      end else begin
        per_d = per_q + CW'(1);
      end
    end
    if (release_cmd) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      per_q  <= per_d;
      flag_q <= flag_d;
    end
  end

  assign timeout = flag_q;

endmodule

// File: rtl/tbwd_irq_mux.sv
module tbwd_irq_mux (
  input  logic irq_en,
  input  logic wdt_mode,
  input  logic tb_pulse,
  input  logic wdt_flag,
  output logic irq_o,
  output logic irq_oe
);

  logic src_low;

  always_comb begin
    src_low = wdt_mode ? wdt_flag : tb_pulse;
    irq_oe  = irq_en;
    irq_o   = ~(irq_en & src_low);
  end

endmodule

// File: rtl/tbwd_irq_ctrl.sv
module tbwd_irq_ctrl
  import tbwd_pkg::*;
#(
  parameter int PRE_W    = 16,
  parameter int TAP_BASE = 8,
  parameter int SEL_W    = 3,
  parameter int PERIODS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             ext_clk,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             cmd_sys_en,
  input  logic             cmd_sys_dis,
  input  logic             cmd_tmr_en,
  input  logic             cmd_wdt_en,
  input  logic             cmd_clr_tmr,
  input  logic             cmd_clr_wdt,
  input  logic             cmd_irq_en,
  input  logic             cmd_irq_dis,
  output logic             irq_o,
  output logic             irq_oe
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_s = rst_sync_q[1];

  mode_t            mode;
  logic             wdt_mode;
  logic             sys_run;
  logic             advance;
  logic             pre_clear;
  logic [PRE_W-1:0] pre_cnt;
  logic             tb_evt;
  logic             tb_pulse;
  logic             wdt_flag;

  tbwd_mode_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ext_clk     (ext_clk),
    .sys_on_cmd  (cmd_sys_en),
    .sys_off_cmd (cmd_sys_dis),
    .tmr_on_cmd  (cmd_tmr_en),
    .wdt_on_cmd  (cmd_wdt_en),
    .irq_on_cmd  (cmd_irq_en),
    .irq_off_cmd (cmd_irq_dis),
    .mode        (mode)
  );

  assign sys_run   = mode.sys_run;
  assign wdt_mode  = (mode.src == SRC_WATCHDOG);
  assign advance   = clk_en && mode.sys_run && mode.tb_on;
  assign pre_clear = cmd_clr_tmr || cmd_clr_wdt;

  tbwd_prescaler #(
    .PRE_W    (PRE_W),
    .TAP_BASE (TAP_BASE),
    .SEL_W    (SEL_W)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .advance  (advance),
    .clear    (pre_clear),
    .tap_sel  (tap_sel),
    .count    (pre_cnt),
    .roll_now (tb_evt),
    .pulse    (tb_pulse)
  );

  tbwd_watchdog #(
    .PERIODS (PERIODS)
  ) u_wdt (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .armed       (wdt_mode),
    .period_evt  (tb_evt),
    .clr_cmd     (cmd_clr_wdt),
    .release_cmd (cmd_irq_dis),
    .timeout     (wdt_flag)
  );

  tbwd_irq_mux u_mux (
    .irq_en   (mode.irq_en),
    .wdt_mode (wdt_mode),
    .tb_pulse (tb_pulse),
    .wdt_flag (wdt_flag),
    .irq_o    (irq_o),
    .irq_oe   (irq_oe)
  );

endmodule

// File: rtl/tbwd_irq_chk.sv
module tbwd_irq_chk #(
  parameter int PRE_W = 16
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             ext_clk,
  input logic             cmd_clr_tmr,
  input logic             cmd_clr_wdt,
  input logic             cmd_irq_en,
  input logic             cmd_irq_dis,
  input logic             irq_o,
  input logic             irq_oe,
  input logic             sys_run,
  input logic             wdt_mode,
  input logic [PRE_W-1:0] pre_cnt,
  input logic             tb_pulse,
  input logic             wdt_flag
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !irq_oe |-> irq_o);

  p_single_low_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    tb_pulse |=> !tb_pulse);

  p_wdt_drives_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_oe && wdt_mode && wdt_flag) |-> !irq_o);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wdt_flag && !cmd_clr_wdt && !cmd_irq_dis) |=> wdt_flag);

  p_clr_wdt_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_clr_wdt |=> (!wdt_flag && pre_cnt == '0));

  p_clr_tmr_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_clr_tmr |=> (pre_cnt == '0));

  p_oe_rise_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq_oe) |-> $past(cmd_irq_en));

  p_off_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sys_run && !cmd_clr_tmr && !cmd_clr_wdt) |=> $stable(pre_cnt));

  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sys_run |=> !tb_pulse);

  p_ext_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ext_clk && sys_run) |=> sys_run);

endmodule

bind tbwd_irq_ctrl tbwd_irq_chk #(.PRE_W(PRE_W)) u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .ext_clk     (ext_clk),
  .cmd_clr_tmr (cmd_clr_tmr),
  .cmd_clr_wdt (cmd_clr_wdt),
  .cmd_irq_en  (cmd_irq_en),
  .cmd_irq_dis (cmd_irq_dis),
  .irq_o       (irq_o),
  .irq_oe      (irq_oe),
  .sys_run     (sys_run),
  .wdt_mode    (wdt_mode),
  .pre_cnt     (pre_cnt),
  .tb_pulse    (tb_pulse),
  .wdt_flag    (wdt_flag)
);

// File: tb/tbwd_irq_ctrl_bench.sv
module tbwd_irq_ctrl_bench;

  localparam int PRE_W    = 16;
  localparam int TAP_BASE = 8;
  localparam int SEL_W    = 3;
  localparam int PERIODS  = 4;

  logic             clk;
  logic             rst_n;
  logic             clk_en;
  logic             ext_clk;
  logic [SEL_W-1:0] tap_sel;
  logic             cmd_sys_en, cmd_sys_dis, cmd_tmr_en, cmd_wdt_en;
  logic             cmd_clr_tmr, cmd_clr_wdt, cmd_irq_en, cmd_irq_dis;
  logic             irq_o;
  logic             irq_oe;

  tbwd_irq_ctrl #(
    .PRE_W(PRE_W), .TAP_BASE(TAP_BASE), .SEL_W(SEL_W), .PERIODS(PERIODS)
  ) u_tbwd_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ext_clk(ext_clk), .tap_sel(tap_sel),
    .cmd_sys_en(cmd_sys_en), .cmd_sys_dis(cmd_sys_dis), .cmd_tmr_en(cmd_tmr_en),
    .cmd_wdt_en(cmd_wdt_en), .cmd_clr_tmr(cmd_clr_tmr), .cmd_clr_wdt(cmd_clr_wdt),
    .cmd_irq_en(cmd_irq_en), .cmd_irq_dis(cmd_irq_dis), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference state, built from the requirements.
  bit m_sys, m_tmr, m_src, m_irq, m_pulse, m_flag;
  int m_cnt, m_wcnt;
  int en_mode = 0;
  bit alt     = 1'b1;

  function automatic bit tap_full(int cnt, int sel);
    int mask;
    mask = (2 << (TAP_BASE + sel)) - 1;
    return (cnt & mask) == mask;
  endfunction

  function automatic logic exp_irq();
    if (!m_irq) return 1'b1;
    return m_src ? !m_flag : !m_pulse;
  endfunction

  task automatic model_step();
    bit adv, clr, ev;
    adv = clk_en && m_sys && m_tmr;
    clr = cmd_clr_tmr || cmd_clr_wdt;
    ev  = adv && !clr && tap_full(m_cnt, int'(tap_sel));
    if (cmd_clr_wdt) begin
      m_wcnt = 0; m_flag = 1'b0;
    end else if (ev && m_src) begin
      if (m_wcnt == PERIODS - 1) begin m_wcnt = 0; m_flag = 1'b1; end
      else m_wcnt = m_wcnt + 1;
    end
    if (cmd_irq_dis) m_flag = 1'b0;
    if (clr) m_cnt = 0;
    else if (adv) m_cnt = (m_cnt + 1) % (1 << PRE_W);
    m_pulse = ev;
    if (cmd_sys_dis && !ext_clk) m_sys = 1'b0;
    else if (cmd_sys_en) m_sys = 1'b1;
    if (cmd_wdt_en) begin m_tmr = 1'b1; m_src = 1'b1; end
    else if (cmd_tmr_en) begin m_tmr = 1'b1; m_src = 1'b0; end
    if (cmd_irq_dis) m_irq = 1'b0;
    else if (cmd_irq_en) m_irq = 1'b1;
  endtask

  task automatic check(string req, string what, logic act, logic expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, expv);
    end
  endtask

  task automatic check_int(string req, string what, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clear_cmds();
    cmd_sys_en = 0; cmd_sys_dis = 0; cmd_tmr_en = 0; cmd_wdt_en = 0;
    cmd_clr_tmr = 0; cmd_clr_wdt = 0; cmd_irq_en = 0; cmd_irq_dis = 0;
  endtask

  // One clock: inputs already set after a falling edge.
  task automatic cycle(string req);
    if (en_mode == 0) clk_en = 1'b1;
    else if (en_mode == 1) begin clk_en = alt; alt = !alt; end
    else clk_en = ($urandom % 8) != 0;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(req, "irq_oe vs model", irq_oe, m_irq);
    check(req, "irq_o vs model", irq_o, exp_irq());
    clear_cmds();
  endtask

  task automatic run_until_low(string req, int limit, output int n);
    n = limit;
    for (int k = 1; k <= limit; k++) begin
      cycle(req);
      if (irq_o === 1'b0) begin n = k; break; end
    end
  endtask

  task automatic run(string req, int cycles);
    for (int k = 0; k < cycles; k++) cycle(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int lows;
    void'($urandom(32'h1ce5eed));
    m_sys = 0; m_tmr = 0; m_src = 0; m_irq = 0; m_pulse = 0; m_flag = 0;
    m_cnt = 0; m_wcnt = 0;
    rst_n = 0; clk_en = 0; ext_clk = 0; tap_sel = '0;
    clear_cmds();
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state, nothing runs without commands
    check("R1", "reset irq_oe", irq_oe, 1'b0);
    check("R1", "reset irq_o", irq_o, 1'b1);
    run("R1", 600);
    cmd_irq_en = 1; cycle("R1");
    check("R1", "oe after enable", irq_oe, 1'b1);
    run_until_low("R1", 1100, n);
    check_int("R1", "no pulse while stopped", n, 1100);
    check("R1", "pin high while stopped", irq_o, 1'b1);

    // R2: time base period per tap
    cmd_sys_en = 1; cmd_tmr_en = 1; cmd_clr_tmr = 1; cycle("R2");
    run_until_low("R2", 4000, n);
    check_int("R2", "first low tap0", n, 512);
    run_until_low("R2", 4000, n);
    check_int("R2", "period tap0", n, 512);
    cycle("R2");
    check("R2", "low lasts one cycle", irq_o, 1'b1);
    tap_sel = 3'd1; cmd_clr_tmr = 1; cycle("R2");
    run_until_low("R2", 4000, n);
    check_int("R2", "period tap1", n, 1024);
    tap_sel = 3'd2; cmd_clr_tmr = 1; cycle("R2");
    run_until_low("R2", 4000, n);
    check_int("R2", "period tap2", n, 2048);

    // R3: clk_en gating
    tap_sel = 3'd0; en_mode = 1; alt = 1'b1; cmd_clr_tmr = 1; cycle("R3");
    run_until_low("R3", 4000, n);
    check_int("R3", "half-rate first low", n, 1024);
    en_mode = 0;

    // R4/R5: watchdog routing, timeout and hold
    cmd_wdt_en = 1; cmd_clr_wdt = 1; cycle("R5");
    run_until_low("R5", 5000, n);
    check_int("R5", "timeout after four periods", n, 2048);
    lows = 0;
    for (int k = 0; k < 700; k++) begin
      cycle("R4");
      if (irq_o === 1'b0) lows++;
    end
    check_int("R5", "held low cycles", lows, 700);

    // R6: clear semantics
    cmd_clr_wdt = 1; cycle("R6");
    check("R6", "clear wdt releases pin", irq_o, 1'b1);
    run("R6", 600);
    cmd_clr_tmr = 1; cycle("R6");
    run_until_low("R6", 5000, n);
    check_int("R6", "clear timer keeps wdt periods", n, 1536);

    // R7: disable floats pin and releases timeout
    cmd_irq_dis = 1; cycle("R7");
    check("R7", "oe after disable", irq_oe, 1'b0);
    check("R7", "pin idle high", irq_o, 1'b1);
    cmd_irq_en = 1; cycle("R7");
    check("R7", "oe after enable", irq_oe, 1'b1);
    check("R7", "timeout released", irq_o, 1'b1);

    // R4: timer enable hides watchdog flag
    run_until_low("R4", 5000, n);
    check("R4", "wdt timeout visible", irq_o, 1'b0);
    cmd_tmr_en = 1; cycle("R4");
    check("R4", "flag hidden in timer mode", irq_o, 1'b1);
    cmd_clr_wdt = 1; cycle("R4");

    // R8: power-down freezes counting
    cmd_clr_tmr = 1; cycle("R8");
    run("R8", 300);
    cmd_sys_dis = 1; cycle("R8");
    run_until_low("R8", 3000, n);
    check_int("R8", "no pulse while off", n, 3000);
    cmd_sys_en = 1; cycle("R8");
    run_until_low("R8", 2000, n);
    check_int("R8", "resume from held count", n, 211);

    // R9: external clock ignores system-off
    ext_clk = 1; cmd_sys_dis = 1; cycle("R9");
    run_until_low("R9", 1000, n);
    check("R9", "pulse continues", irq_o, 1'b0);
    check_int("R9", "pulse within period", int'(n <= 512), 1);
    ext_clk = 0;

    // R10: same-cycle priorities
    cmd_irq_en = 1; cmd_irq_dis = 1; cycle("R10");
    check("R10", "disable wins", irq_oe, 1'b0);
    cmd_irq_en = 1; cycle("R10");
    cmd_wdt_en = 1; cmd_tmr_en = 1; cmd_clr_wdt = 1; cycle("R10");
    run_until_low("R10", 5000, n);
    check_int("R10", "watchdog wins over timer", n, 2048);
    cmd_tmr_en = 1; cmd_clr_wdt = 1; cycle("R10");
    run("R10", 511);
    cmd_clr_tmr = 1; cycle("R10");
    check("R10", "clear suppresses rollover", irq_o, 1'b1);
    run_until_low("R10", 2000, n);
    check_int("R10", "period restarts after clear", n, 512);

    // Random phase against the reference
    en_mode = 2;
    for (int k = 0; k < 40000; k++) begin
      int r;
      r = int'($urandom % 2000);
      case (r)
        0: cmd_sys_dis = 1;
        1, 2: cmd_sys_en = 1;
        3: cmd_tmr_en = 1;
        4: cmd_wdt_en = 1;
        5: cmd_clr_tmr = 1;
        6: cmd_clr_wdt = 1;
        7: cmd_irq_en = 1;
        8: cmd_irq_dis = 1;
        9: tap_sel = SEL_W'($urandom % 2);
        10: ext_clk = !ext_clk;
        default: ;
      endcase
      cycle("R2-random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule